// File: doc/BRIEF.md
# Dual-Side Mailbox Register File

This block is a small byte-wide register file that sits between a host processor and a management controller, each reaching it through its own synchronous register port. Both sides share a bank of general data bytes used to pass a command, a sequence number, a payload and a response. They also share a flag byte and sixteen status bits that the controller uses to post asynchronous news to the host. Each side owns a control byte and two interrupt-enable bytes.

A side rings the other by writing its send bit. This raises a pending bit in the peer's control byte, and the peer clears that bit by writing one to it. Each side has an active-low, level interrupt output. It is driven from its own pending bit, gated by its own mask bit, and from the status bits that side has enabled. Reads are registered: the byte addressed in a read-strobe cycle appears on read data one clock later and holds there until the next read.

Top module: `mailbox_regfile`

## Requirements
- R1: Asynchronous active-low reset clears every register. After reset, every offset reads 0x00 from both ports and both interrupt outputs are high.
- R2: Offsets 0x00 to 0x0E are data bytes that both ports can write and read. Read data shows the byte addressed in a read-strobe cycle after the next clock edge, and holds until the next read strobe.
- R3: When both ports write the same data or flag offset in one cycle, the controller port's value is stored.
- R4: The host's control byte is at 0x13 and the controller's is at 0x12. A side that writes a one to bit 0 of its own control byte sets bit 7 (pending) of the other side's control byte. Bit 0 always reads zero.
- R5: Writing a one to bit 7 of a side's own control byte clears its pending bit, and writing a zero there leaves it unchanged. If the peer sends in the same cycle, the pending bit stays set.
- R6: Bit 1 of a control byte is a read/write mask bit, and bits 6..2 read zero. Writes to the other side's control byte or enable bytes are ignored.
- R7: Offset 0x0F is a flag byte that both ports can write. A controller write to it also sets status bit 15 (bit 7 of 0x11). A host write to it does not.
- R8: Status bytes are at 0x10 (bits 7..0) and 0x11 (bits 15..8). A controller write of one sets a bit and a host write of one clears it. A written zero has no effect, and when a set and a clear meet in one cycle the set wins.
- R9: A side's interrupt output is low exactly while (its pending bit is set and its mask bit is clear) or any status bit is set whose enable bit for that side is set. The controller's enables are at 0x14/0x15 and the host's at 0x16/0x17, with the low byte covering status bits 7..0.
- R10: Writes to offsets above 0x17 change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_addr | input | ADDR_W | Host port byte offset |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rd | input | 1 | Host read strobe |
| hst_rdata | output | 8 | Host read data, registered |
| hst_irq_n | output | 1 | Interrupt toward host, active low |
| mc_addr | input | ADDR_W | Controller port byte offset |
| mc_wr | input | 1 | Controller write strobe |
| mc_wdata | input | 8 | Controller write data |
| mc_rd | input | 1 | Controller read strobe |
| mc_rdata | output | 8 | Controller read data, registered |
| mc_irq_n | output | 1 | Interrupt toward controller, active low |

## Verification
A wrong pending, mask or status bit shows on the interrupt outputs in the very cycle after the write that caused it, because those outputs are decoded from register state with no further stage. A wrong stored byte, a lost collision or a stray write to a foreign or unimplemented offset stays hidden until that offset is read back. It then shows one clock after the read strobe, so the bench reads back every offset a stimulus could have touched. A stuck read-data register shows as a stale value on the next read of a different offset.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
   typedef logic [7:0] byte_t;

   localparam int NUM_SIDES    = 2;
   localparam int SIDE_HST     = 0;
   localparam int SIDE_MC      = 1;

   localparam int OFF_FLAG     = 15;
   localparam int OFF_STS0     = 16;
   localparam int OFF_STS1     = 17;
   localparam int OFF_CTRL_MC  = 18;
   localparam int OFF_CTRL_HST = 19;
   localparam int OFF_EN_MC    = 20;
   localparam int OFF_EN_HST   = 22;
   localparam int OFF_LAST     = 23;

   localparam int BIT_SEND     = 0;
   localparam int BIT_MASK     = 1;
   localparam int BIT_PEND     = 7;
   localparam int FLAG_STS_BIT = 15;
endpackage

// File: rtl/mbox_data_bank.sv
`timescale 1ns/1ps
module mbox_data_bank
   import mbox_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_DATA = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hst_wr,
   input  logic [ADDR_W-1:0]     hst_addr,
   input  byte_t                 hst_wdata,
   input  logic                  mc_wr,
   input  logic [ADDR_W-1:0]     mc_addr,
   input  byte_t                 mc_wdata,
   output logic [NUM_DATA:0][7:0] bank_q
);
   // entries 0..NUM_DATA-1 are data bytes, entry NUM_DATA is the flag byte
   for (genvar i = 0; i <= NUM_DATA; i++) begin : g_byte
      localparam int OFF = (i == NUM_DATA) ? OFF_FLAG : i;
      logic hst_hit, mc_hit;
      byte_t q;
      assign hst_hit = hst_wr && (hst_addr == ADDR_W'(OFF));
      assign mc_hit  = mc_wr  && (mc_addr  == ADDR_W'(OFF));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (mc_hit)  q <= mc_wdata;
         else if (hst_hit) q <= hst_wdata;
      end
      assign bank_q[i] = q;

      assert_mc_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (hst_hit && mc_hit) |=> (q == $past(mc_wdata)));
   end
endmodule

// File: rtl/mbox_status.sv
`timescale 1ns/1ps
module mbox_status
   import mbox_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  byte_t             hst_wdata,
   input  logic              mc_wr,
   input  logic [ADDR_W-1:0] mc_addr,
   input  byte_t             mc_wdata,
   output logic [15:0]       sts_q
);
   logic        flag_wr;
   logic [15:0] set_v, clr_v;
   assign flag_wr = mc_wr && (mc_addr == ADDR_W'(OFF_FLAG));

   for (genvar b = 0; b < 2; b++) begin : g_sbyte
      localparam int OFF = OFF_STS0 + b;
      byte_t set_b, clr_b, q;
      always_comb begin
         set_b = (mc_wr && mc_addr == ADDR_W'(OFF)) ? mc_wdata : '0;
         if (b == 1 && flag_wr) set_b[FLAG_STS_BIT - 8] = 1'b1;
         clr_b = (hst_wr && hst_addr == ADDR_W'(OFF)) ? hst_wdata : '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= (q & ~clr_b) | set_b;
      end
      assign sts_q[8*b +: 8] = q;
      assign set_v[8*b +: 8] = set_b;
      assign clr_v[8*b +: 8] = clr_b;
   end

   assert_flag_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> sts_q[FLAG_STS_BIT]);
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != 0) |=> ((sts_q & $past(set_v)) == $past(set_v)));
   assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_v != 0) && (set_v == 0)) |=> ((sts_q & $past(clr_v)) == 16'h0000));
endmodule

// File: rtl/mbox_side.sv
`timescale 1ns/1ps
module mbox_side
   import mbox_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFF = OFF_CTRL_HST,
   parameter int EN_OFF   = OFF_EN_HST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  byte_t             wdata,
   input  logic              peer_send,
   input  logic [15:0]       sts,
   output logic              send_o,
   output byte_t             ctrl_byte,
   output logic [15:0]       en_q,
   output logic              irq_n
);
   logic  ctrl_hit, pend_q, mask_q;
   byte_t en_b [2];

   assign ctrl_hit = wr && (addr == ADDR_W'(CTRL_OFF));
   assign send_o   = ctrl_hit && wdata[BIT_SEND];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (peer_send)                          pend_q <= 1'b1;
         else if (ctrl_hit && wdata[BIT_PEND])   pend_q <= 1'b0;
         if (ctrl_hit)                           mask_q <= wdata[BIT_MASK];
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_en
      logic hit;
      assign hit = wr && (addr == ADDR_W'(EN_OFF + b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   en_b[b] <= '0;
         else if (hit) en_b[b] <= wdata;
      end
   end
   assign en_q = {en_b[1], en_b[0]};

   always_comb begin
      ctrl_byte           = '0;
      ctrl_byte[BIT_PEND] = pend_q;
      ctrl_byte[BIT_MASK] = mask_q;
   end

   assign irq_n = !((pend_q && !mask_q) || ((sts & en_q) != 16'h0000));

   assert_peer_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      peer_send |=> pend_q);
   assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && wdata[BIT_PEND] && !peer_send) |=> !pend_q);
   assert_keep_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(ctrl_hit && wdata[BIT_PEND])) |=> pend_q);
   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && ((sts & en_q) == 16'h0000)) |-> irq_n);
endmodule

// File: rtl/mailbox_regfile.sv
`timescale 1ns/1ps
module mailbox_regfile
   import mbox_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_DATA = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic              hst_wr,
   input  logic [7:0]        hst_wdata,
   input  logic              hst_rd,
   output logic [7:0]        hst_rdata,
   output logic              hst_irq_n,
   input  logic [ADDR_W-1:0] mc_addr,
   input  logic              mc_wr,
   input  logic [7:0]        mc_wdata,
   input  logic              mc_rd,
   output logic [7:0]        mc_rdata,
   output logic              mc_irq_n
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x17");
   end
   if (NUM_DATA < 1 || NUM_DATA > OFF_FLAG) begin : g_bad_data
      $error("NUM_DATA must lie in 1..15");
   end

   logic [ADDR_W-1:0]     addr_a [NUM_SIDES];
   logic                  wr_a   [NUM_SIDES];
   logic                  rd_a   [NUM_SIDES];
   byte_t                 wd_a   [NUM_SIDES];
   byte_t                 rq_a   [NUM_SIDES];
   logic                  irq_a  [NUM_SIDES];
   logic                  send_a [NUM_SIDES];
   byte_t                 ctrl_a [NUM_SIDES];
   logic [15:0]           en_a   [NUM_SIDES];
   logic [NUM_DATA:0][7:0] bank_q;
   logic [15:0]           sts_q;

   assign addr_a[SIDE_HST] = hst_addr;  assign addr_a[SIDE_MC] = mc_addr;
   assign wr_a[SIDE_HST]   = hst_wr;    assign wr_a[SIDE_MC]   = mc_wr;
   assign rd_a[SIDE_HST]   = hst_rd;    assign rd_a[SIDE_MC]   = mc_rd;
   assign wd_a[SIDE_HST]   = hst_wdata; assign wd_a[SIDE_MC]   = mc_wdata;
   assign hst_rdata = rq_a[SIDE_HST];   assign mc_rdata  = rq_a[SIDE_MC];
   assign hst_irq_n = irq_a[SIDE_HST];  assign mc_irq_n  = irq_a[SIDE_MC];

   mbox_data_bank #(.ADDR_W(ADDR_W), .NUM_DATA(NUM_DATA)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .mc_wr(mc_wr), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
      .bank_q(bank_q));

   mbox_status #(.ADDR_W(ADDR_W)) status_i (
      .clk(clk), .rst_n(rst_n),
      .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .mc_wr(mc_wr), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
      .sts_q(sts_q));

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam int CTRL_OFF = (s == SIDE_MC) ? OFF_CTRL_MC : OFF_CTRL_HST;
      localparam int EN_OFF   = (s == SIDE_MC) ? OFF_EN_MC   : OFF_EN_HST;
      byte_t rd_mux;

      mbox_side #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .EN_OFF(EN_OFF)) side_i (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_a[s]), .addr(addr_a[s]), .wdata(wd_a[s]),
         .peer_send(send_a[NUM_SIDES-1-s]), .sts(sts_q),
         .send_o(send_a[s]), .ctrl_byte(ctrl_a[s]), .en_q(en_a[s]),
         .irq_n(irq_a[s]));

      always_comb begin
         rd_mux = '0;
         for (int i = 0; i < NUM_DATA; i++)
            if (addr_a[s] == ADDR_W'(i)) rd_mux = bank_q[i];
         if (addr_a[s] == ADDR_W'(OFF_FLAG))       rd_mux = bank_q[NUM_DATA];
         if (addr_a[s] == ADDR_W'(OFF_STS0))       rd_mux = sts_q[7:0];
         if (addr_a[s] == ADDR_W'(OFF_STS1))       rd_mux = sts_q[15:8];
         if (addr_a[s] == ADDR_W'(OFF_CTRL_MC))    rd_mux = ctrl_a[SIDE_MC];
         if (addr_a[s] == ADDR_W'(OFF_CTRL_HST))   rd_mux = ctrl_a[SIDE_HST];
         if (addr_a[s] == ADDR_W'(OFF_EN_MC))      rd_mux = en_a[SIDE_MC][7:0];
         if (addr_a[s] == ADDR_W'(OFF_EN_MC + 1))  rd_mux = en_a[SIDE_MC][15:8];
         if (addr_a[s] == ADDR_W'(OFF_EN_HST))     rd_mux = en_a[SIDE_HST][7:0];
         if (addr_a[s] == ADDR_W'(OFF_EN_HST + 1)) rd_mux = en_a[SIDE_HST][15:8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rq_a[s] <= '0;
         else if (rd_a[s])  rq_a[s] <= rd_mux;
      end

      assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_a[s] |=> $stable(rq_a[s]));
      assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_a[s] && addr_a[s] > ADDR_W'(OFF_LAST)) |=> (rq_a[s] == 8'h00));
      assert_send_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_a[s][BIT_SEND] == 1'b0);
      assert_reset_quiet_R1: assert property (@(posedge clk)
         $rose(rst_n) |-> (irq_a[s] && rq_a[s] == 8'h00));
   end
endmodule

// File: tb/mailbox_regfile_tb.sv
`timescale 1ns/1ps
module mailbox_regfile_tb_top;
   localparam int AW = 8;
   localparam int HST = 0;
   localparam int MC  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] hst_addr = '0, mc_addr = '0;
   logic hst_wr = 0, hst_rd = 0, mc_wr = 0, mc_rd = 0;
   logic [7:0] hst_wdata = '0, mc_wdata = '0;
   logic [7:0] hst_rdata, mc_rdata;
   logic hst_irq_n, mc_irq_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   mailbox_regfile #(.ADDR_W(AW), .NUM_DATA(15)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
      .hst_rd(hst_rd), .hst_rdata(hst_rdata), .hst_irq_n(hst_irq_n),
      .mc_addr(mc_addr), .mc_wr(mc_wr), .mc_wdata(mc_wdata),
      .mc_rd(mc_rd), .mc_rdata(mc_rdata), .mc_irq_n(mc_irq_n));

   typedef struct packed {
      logic       is_rd;
      logic       side;
      logic [7:0] addr;
      logic [7:0] val;
      logic [3:0] req;
   } vec_t;

   // R2 data, R10 unimplemented, R6 mask/foreign, R8 status, R7 flag
   localparam int NV = 32;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,8'h00,8'h5A,4'd2}, '{1'b1,1'b1,8'h00,8'h5A,4'd2},
      '{1'b0,1'b1,8'h0D,8'h01,4'd2}, '{1'b1,1'b0,8'h0D,8'h01,4'd2},
      '{1'b0,1'b0,8'h05,8'hC3,4'd2}, '{1'b1,1'b0,8'h05,8'hC3,4'd2},
      '{1'b0,1'b0,8'h20,8'hFF,4'd10},'{1'b1,1'b0,8'h20,8'h00,4'd10},
      '{1'b1,1'b1,8'h18,8'h00,4'd10},'{1'b0,1'b0,8'h13,8'h02,4'd6},
      '{1'b1,1'b0,8'h13,8'h02,4'd6}, '{1'b0,1'b1,8'h13,8'h00,4'd6},
      '{1'b1,1'b0,8'h13,8'h02,4'd6}, '{1'b0,1'b0,8'h12,8'h02,4'd6},
      '{1'b1,1'b1,8'h12,8'h00,4'd6}, '{1'b0,1'b1,8'h10,8'h81,4'd8},
      '{1'b1,1'b0,8'h10,8'h81,4'd8}, '{1'b0,1'b0,8'h10,8'h01,4'd8},
      '{1'b1,1'b1,8'h10,8'h80,4'd8}, '{1'b0,1'b1,8'h10,8'h00,4'd8},
      '{1'b1,1'b0,8'h10,8'h80,4'd8}, '{1'b0,1'b0,8'h10,8'h80,4'd8},
      '{1'b1,1'b0,8'h10,8'h00,4'd8}, '{1'b0,1'b0,8'h0F,8'h02,4'd7},
      '{1'b1,1'b1,8'h0F,8'h02,4'd7}, '{1'b1,1'b0,8'h11,8'h00,4'd7},
      '{1'b0,1'b1,8'h0F,8'h01,4'd7}, '{1'b1,1'b0,8'h0F,8'h01,4'd7},
      '{1'b1,1'b0,8'h11,8'h80,4'd7}, '{1'b0,1'b0,8'h11,8'h80,4'd7},
      '{1'b1,1'b1,8'h11,8'h00,4'd7}, '{1'b0,1'b0,8'h13,8'h00,4'd6}
   };

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_wr(input int s, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      if (s == MC) begin mc_wr = 1; mc_addr = a; mc_wdata = d; end
      else         begin hst_wr = 1; hst_addr = a; hst_wdata = d; end
      @(negedge clk);
      mc_wr = 0; hst_wr = 0;
   endtask

   task automatic do_both(input logic [7:0] ha, input logic [7:0] hd,
                          input logic [7:0] ma, input logic [7:0] md);
      @(negedge clk);
      hst_wr = 1; hst_addr = ha; hst_wdata = hd;
      mc_wr  = 1; mc_addr  = ma; mc_wdata  = md;
      @(negedge clk);
      mc_wr = 0; hst_wr = 0;
   endtask

   task automatic do_rd(input int s, input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      if (s == MC) begin mc_rd = 1; mc_addr = a; end
      else         begin hst_rd = 1; hst_addr = a; end
      @(negedge clk);
      mc_rd = 0; hst_rd = 0;
      v = (s == MC) ? mc_rdata : hst_rdata;
   endtask

   task automatic rd_chk(input int req, input int s, input logic [7:0] a, input logic [7:0] e);
      logic [7:0] v;
      do_rd(s, a, v);
      check(req, v, e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state on every offset, both ports
      check(1, {7'd0, hst_irq_n}, 8'h01);
      check(1, {7'd0, mc_irq_n}, 8'h01);
      for (int a = 0; a < 24; a++) begin
         rd_chk(1, HST, 8'(a), 8'h00);
         rd_chk(1, MC,  8'(a), 8'h00);
      end

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_rd) rd_chk(int'(VECS[i].req), int'(VECS[i].side), VECS[i].addr, VECS[i].val);
         else               do_wr(int'(VECS[i].side), VECS[i].addr, VECS[i].val);
      end

      // R2: read data holds while no read strobe
      rd_chk(2, HST, 8'h05, 8'hC3);
      @(negedge clk);
      check(2, hst_rdata, 8'hC3);

      // R3: same-cycle write to one data offset, controller value kept
      do_both(8'h03, 8'h11, 8'h03, 8'h22);
      rd_chk(3, HST, 8'h03, 8'h22);
      do_both(8'h0F, 8'hAA, 8'h0F, 8'h55);
      rd_chk(3, MC, 8'h0F, 8'h55);
      do_wr(HST, 8'h11, 8'h80); // clear status 15 raised by that flag write

      // R4: controller send pends host side, send bit reads zero
      do_wr(MC, 8'h12, 8'h01);
      check(9, {7'd0, hst_irq_n}, 8'h00);
      check(9, {7'd0, mc_irq_n}, 8'h01);
      rd_chk(4, HST, 8'h13, 8'h80);
      rd_chk(4, MC, 8'h12, 8'h00);
      // R6: mask silences, unmask with bit7=0 keeps pending (R5)
      do_wr(HST, 8'h13, 8'h02);
      check(6, {7'd0, hst_irq_n}, 8'h01);
      rd_chk(6, HST, 8'h13, 8'h82);
      do_wr(HST, 8'h13, 8'h00);
      check(5, {7'd0, hst_irq_n}, 8'h00);
      // R5: write one to bit 7 clears
      do_wr(HST, 8'h13, 8'h80);
      check(5, {7'd0, hst_irq_n}, 8'h01);
      rd_chk(5, HST, 8'h13, 8'h00);
      // R5: send and clear in one cycle, pending stays
      do_both(8'h13, 8'h80, 8'h12, 8'h01);
      rd_chk(5, HST, 8'h13, 8'h80);
      do_wr(HST, 8'h13, 8'h80);

      // R4: host send toward controller
      do_wr(HST, 8'h13, 8'h01);
      check(4, {7'd0, mc_irq_n}, 8'h00);
      rd_chk(4, MC, 8'h12, 8'h80);
      do_wr(MC, 8'h12, 8'h80);
      check(5, {7'd0, mc_irq_n}, 8'h01);

      // R9: status-driven interrupts through per-side enables
      do_wr(HST, 8'h17, 8'h80);
      do_wr(MC, 8'h0F, 8'h02);
      check(9, {7'd0, hst_irq_n}, 8'h00);
      check(9, {7'd0, mc_irq_n}, 8'h01);
      do_wr(MC, 8'h15, 8'h80);
      check(9, {7'd0, mc_irq_n}, 8'h00);
      do_wr(HST, 8'h15, 8'hFF); // R6 foreign enable write ignored
      rd_chk(6, MC, 8'h15, 8'h80);
      do_wr(HST, 8'h11, 8'h80);
      check(9, {7'd0, hst_irq_n}, 8'h01);
      check(9, {7'd0, mc_irq_n}, 8'h01);

      // R8: set and clear of one bit in one cycle, set wins
      do_both(8'h10, 8'h04, 8'h10, 8'h04);
      rd_chk(8, HST, 8'h10, 8'h04);

      // R1: reset mid-run clears all
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      check(1, {7'd0, hst_irq_n}, 8'h01);
      rd_chk(1, HST, 8'h00, 8'h00);
      rd_chk(1, MC, 8'h10, 8'h00);
      rd_chk(1, MC, 8'h15, 8'h00);
      rd_chk(1, HST, 8'h17, 8'h00);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule